// File: doc/BRIEF.md
# Shared Memory Hold Arbiter

This block decides who owns a shared SRAM that sits between a main processor and a slave processor. The slave runs on its own clock and has no way to stretch its bus cycles, so it cannot wait for the memory. Its strobes reach this block asynchronously. When the slave touches the shared window and the arbiter is idle, the arbiter raises a hold request toward the main processor. It then waits for the hold acknowledge before it grants the bus to the slave. The access that started this acquisition is a dummy read, and its data is meaningless. The slave checks a data-valid flag to learn when its later accesses are served.

Once granted, the bus stays with the slave across a whole block transfer. The arbiter gives the bus back to the main processor in one of two ways: the slave writes to a dedicated release address, or no shared access arrives for an idle window (340 µs by default, counted in system clocks). When it gives the bus back, it drops the hold request and waits for the acknowledge to fall before it returns to idle. A saturating counter records accesses that could not be served. A small mailbox of flag bits lets the two processors signal each other without touching memory.

Top module: `shm_hold_arbiter`

## Requirements
- R1: After reset, hold_req_o, grant_o and data_valid_o are 0, err_count_o is 0 and flags_o is all zero.
- R2: A slave read whose address lies in the shared window (SHR_BASE up to but not including SHR_BASE+SHR_SPAN), made while idle, raises hold_req_o. grant_o stays 0 until hold_ack_i has been seen high.
- R3: While granted, further shared reads and writes to any address other than REL_ADDR keep grant_o and hold_req_o at 1.
- R4: A slave write to REL_ADDR while granted drops hold_req_o and grant_o. After hold_ack_i falls, the arbiter is idle again, so a new shared read raises hold_req_o once more.
- R5: While granted, the arbiter releases the bus after TMO_US*CLK_MHZ clock cycles with no shared access. Every shared access restarts that count.
- R6: A slave access whose address lies outside the shared window does not raise hold_req_o and does not change err_count_o.
- R7: data_valid_o is 1 only while the bus is granted and hold_ack_i is high. It is 0 while the request is still pending.
- R8: err_count_o increments by one for each shared write made while idle and for each shared access made while a request or a release is pending. The read that starts acquisition from idle is not counted. The counter saturates at its all-ones value.
- R9: For each mailbox bit i whose OWN_MASK bit is 1, a rising edge on slv_flag_i[i] sets flags_o[i] and a high mst_flag_i[i] clears it. For a bit whose OWN_MASK bit is 0, the roles are swapped. flags_o can be read at any time, whatever the ownership of the bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slv_rd_i | input | 1 | Slave read strobe, asynchronous; its rising edge marks an access |
| slv_wr_i | input | 1 | Slave write strobe, asynchronous; its rising edge marks an access |
| slv_addr_i | input | ADDR_W | Slave address, held stable while a strobe is high |
| slv_flag_i | input | NFLAG | Slave mailbox strobes, asynchronous and edge-detected |
| hold_req_o | output | 1 | Hold request to the main processor |
| hold_ack_i | input | 1 | Hold acknowledge from the main processor |
| grant_o | output | 1 | Shared memory owned by the slave |
| data_valid_o | output | 1 | Slave accesses are being served |
| err_count_o | output | ERR_W | Saturating count of unserved accesses |
| mst_flag_i | input | NFLAG | Main-processor mailbox pulses, synchronous |
| flags_o | output | NFLAG | Mailbox flag bits |

## Verification
The assertions rely on a few assumptions about the inputs. Each slave strobe is high for at least three clocks and low for at least three clocks. The address does not change while a strobe is high. hold_ack_i changes only in response to hold_req_o, and only after a few clocks. The bench keeps to these rules: every strobe lasts four clocks, followed by a gap of three. The main processor is modelled as a three-stage delay from hold_req_o to hold_ack_i, and that delay can be switched off to leave a request pending. The idle-window checks sample a margin of some clocks on each side of the expiry edge, so the latency of the synchroniser does not blur the result.

// File: rtl/shm_pkg.sv
package shm_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_REQ   = 2'd1,
    ST_GRANT = 2'd2,
    ST_REL   = 2'd3
  } arb_state_t;

  // Idle window in clocks for a given clock rate and window length.
  function automatic int unsigned tmo_cycles(input int unsigned clk_mhz,
                                             input int unsigned win_us);
    return clk_mhz * win_us;
  endfunction

  // True when addr falls inside [base, base+span).
  function automatic logic in_window(input int unsigned addr,
                                     input int unsigned base,
                                     input int unsigned span);
    return (addr >= base) && (addr < base + span);
  endfunction

  // Saturating increment of a counter held in the low w bits.
  function automatic int unsigned sat_inc(input int unsigned val,
                                          input int unsigned w);
    int unsigned top;
    top = (w >= 32) ? 32'hFFFF_FFFF : ((32'd1 << w) - 32'd1);
    return (val >= top) ? top : val + 32'd1;
  endfunction

endpackage

// File: rtl/shm_sync_edge.sv
module shm_sync_edge #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] rise_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic s1, s2, s3;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        s1 <= 1'b0;
        s2 <= 1'b0;
        s3 <= 1'b0;
      end else begin
        s1 <= async_i[i];
        s2 <= s1;
        s3 <= s2;
      end
    end
    assign rise_o[i] = s2 & ~s3;
  end
endmodule

// File: rtl/shm_idle_timer.sv
module shm_idle_timer #(
  parameter int unsigned LIMIT = 68000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  input  logic restart_i,
  output logic expire_o
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n || !run_i || restart_i) cnt <= '0;
    else if (cnt != LAST)              cnt <= cnt + 1'b1;
  end

  assign expire_o = run_i & ~restart_i & (cnt == LAST);

  AST_TMR_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LAST); // R5
endmodule

// File: rtl/shm_mailbox.sv
module shm_mailbox #(
  parameter int             NFLAG    = 4,
  parameter logic [NFLAG-1:0] OWN_MASK = 4'b0011
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NFLAG-1:0] slv_pulse_i,
  input  logic [NFLAG-1:0] mst_pulse_i,
  output logic [NFLAG-1:0] flags_o
);
  logic [NFLAG-1:0] set_vec, clr_vec;

  for (genvar i = 0; i < NFLAG; i++) begin : g_flag
    if (OWN_MASK[i]) begin : g_slv_owned
      assign set_vec[i] = slv_pulse_i[i];
      assign clr_vec[i] = mst_pulse_i[i];
    end else begin : g_mst_owned
      assign set_vec[i] = mst_pulse_i[i];
      assign clr_vec[i] = slv_pulse_i[i];
    end
    always_ff @(posedge clk) begin
      if (!rst_n)          flags_o[i] <= 1'b0;
      else if (set_vec[i]) flags_o[i] <= 1'b1;
      else if (clr_vec[i]) flags_o[i] <= 1'b0;
    end
  end

  AST_MBX_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (set_vec != '0) |=> ((flags_o & $past(set_vec)) == $past(set_vec))); // R9
endmodule

// File: rtl/shm_hold_arbiter.sv
module shm_hold_arbiter
  import shm_pkg::*;
#(
  parameter int               ADDR_W   = 16,
  parameter int unsigned      SHR_BASE = 16'h8000,
  parameter int unsigned      SHR_SPAN = 16'h2000,
  parameter int unsigned      REL_ADDR = 16'h9FFF,
  parameter int unsigned      CLK_MHZ  = 200,
  parameter int unsigned      TMO_US   = 340,
  parameter int               ERR_W    = 4,
  parameter int               NFLAG    = 4,
  parameter logic [NFLAG-1:0] OWN_MASK = 4'b0011
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slv_rd_i,
  input  logic              slv_wr_i,
  input  logic [ADDR_W-1:0] slv_addr_i,
  input  logic [NFLAG-1:0]  slv_flag_i,
  output logic              hold_req_o,
  input  logic              hold_ack_i,
  output logic              grant_o,
  output logic              data_valid_o,
  output logic [ERR_W-1:0]  err_count_o,
  input  logic [NFLAG-1:0]  mst_flag_i,
  output logic [NFLAG-1:0]  flags_o
);
  localparam int unsigned TMO_CYC = tmo_cycles(CLK_MHZ, TMO_US);
  localparam int          SW      = 2 + NFLAG;

  arb_state_t        state, state_nx;
  logic [SW-1:0]     rise;
  logic              rd_evt, wr_evt, shr_hit, shr_acc;
  logic              rel_evt, tmo_evt, err_evt;
  logic [NFLAG-1:0]  slv_flag_evt;

  shm_sync_edge #(.W(SW)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i ({slv_flag_i, slv_wr_i, slv_rd_i}),
    .rise_o  (rise)
  );

  assign rd_evt       = rise[0];
  assign wr_evt       = rise[1];
  assign slv_flag_evt = rise[SW-1:2];

  assign shr_hit = in_window(32'(slv_addr_i), SHR_BASE, SHR_SPAN);
  assign shr_acc = (rd_evt | wr_evt) & shr_hit;
  assign rel_evt = (state == ST_GRANT) & wr_evt & (32'(slv_addr_i) == REL_ADDR);
  assign err_evt = shr_acc & ((state == ST_REQ) | (state == ST_REL) |
                              ((state == ST_IDLE) & wr_evt));

  shm_idle_timer #(.LIMIT(TMO_CYC)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .run_i     (state == ST_GRANT),
    .restart_i (shr_acc),
    .expire_o  (tmo_evt)
  );

  always_comb begin
    state_nx = state;
    unique case (state)
      ST_IDLE:  if (shr_acc)              state_nx = ST_REQ;
      ST_REQ:   if (hold_ack_i)           state_nx = ST_GRANT;
      ST_GRANT: if (rel_evt || tmo_evt)   state_nx = ST_REL;
      ST_REL:   if (!hold_ack_i)          state_nx = ST_IDLE;
      default:                            state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= state_nx;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       err_count_o <= '0;
    else if (err_evt) err_count_o <= ERR_W'(sat_inc(32'(err_count_o), ERR_W));
  end

  assign hold_req_o   = (state == ST_REQ) | (state == ST_GRANT);
  assign grant_o      = (state == ST_GRANT);
  assign data_valid_o = grant_o & hold_ack_i;

  shm_mailbox #(.NFLAG(NFLAG), .OWN_MASK(OWN_MASK)) u_mbox (
    .clk         (clk),
    .rst_n       (rst_n),
    .slv_pulse_i (slv_flag_evt),
    .mst_pulse_i (mst_flag_i),
    .flags_o     (flags_o)
  );

  AST_GRANT_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(grant_o) |-> $past(hold_ack_i)); // R2
  AST_HOLD_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_o && !rel_evt && !tmo_evt) |=> grant_o); // R3
  AST_REQ_FALL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hold_req_o) |-> $past(rel_evt || tmo_evt)); // R4
  AST_ERR_MONO: assert property (@(posedge clk) disable iff (!rst_n)
    err_count_o >= $past(err_count_o)); // R8
  AST_OUTSIDE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == ST_IDLE) && !shr_acc) |=> !hold_req_o); // R6
endmodule

// File: tb/shm_hold_arbiter_test.sv
module shm_hold_arbiter_test;
  localparam int          ADDR_W  = 16;
  localparam int unsigned TMO_CYC = 200 * 340;
  localparam logic [15:0] SHR_A   = 16'h8010;
  localparam logic [15:0] REL_A   = 16'h9FFF;
  localparam logic [15:0] OUT_A   = 16'h1000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic slv_rd = 1'b0, slv_wr = 1'b0;
  logic [ADDR_W-1:0] slv_addr = '0;
  logic [3:0] slv_flag = '0, mst_flag = '0;
  logic hold_req, hold_ack, grant, dvalid;
  logic [3:0] err_cnt, flags;
  logic ack_en = 1'b1;
  logic [2:0] ack_pipe;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  shm_hold_arbiter uut (
    .clk(clk), .rst_n(rst_n), .slv_rd_i(slv_rd), .slv_wr_i(slv_wr),
    .slv_addr_i(slv_addr), .slv_flag_i(slv_flag), .hold_req_o(hold_req),
    .hold_ack_i(hold_ack), .grant_o(grant), .data_valid_o(dvalid),
    .err_count_o(err_cnt), .mst_flag_i(mst_flag), .flags_o(flags)
  );

  // Main-processor model: acknowledge follows request after three clocks.
  initial begin
    ack_pipe = '0;
    hold_ack = 1'b0;
    forever begin
      @(posedge clk);
      #2;
      ack_pipe = {ack_pipe[1:0], hold_req & ack_en};
      hold_ack = ack_pipe[2];
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset;
    rst_n = 1'b0;
    ack_en = 1'b1;
    cyc(4);
    rst_n = 1'b1;
    cyc(6);
  endtask

  task automatic access(input logic [15:0] a, input logic wr);
    slv_addr = a;
    if (wr) slv_wr = 1'b1; else slv_rd = 1'b1;
    cyc(4);
    slv_wr = 1'b0;
    slv_rd = 1'b0;
    cyc(3);
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    cyc(3);
    chk("R1 hold_req", hold_req, 0);
    chk("R1 grant", grant, 0);
    chk("R1 data_valid", dvalid, 0);
    chk("R1 err_count", err_cnt, 0);
    chk("R1 flags", flags, 0);
    rst_n = 1'b1;
    cyc(3);
  endtask

  task automatic t_acquire;
    do_reset();
    ack_en = 1'b0;
    access(SHR_A, 1'b0);
    chk("R2 hold_req after dummy read", hold_req, 1);
    cyc(10);
    chk("R2 no grant without ack", grant, 0);
    chk("R7 data_valid low while pending", dvalid, 0);
    chk("R8 dummy read not counted", err_cnt, 0);
    ack_en = 1'b1;
    cyc(6);
    chk("R2 grant after ack", grant, 1);
    chk("R7 data_valid while granted", dvalid, 1);
  endtask

  task automatic t_sticky;
    do_reset();
    access(SHR_A, 1'b0);
    chk("R3 granted", grant, 1);
    for (int i = 0; i < 5; i++) access(SHR_A + 16'(i), i[0]);
    chk("R3 grant held over block", grant, 1);
    chk("R3 hold_req held", hold_req, 1);
    chk("R3 no errors while granted", err_cnt, 0);
  endtask

  task automatic t_release;
    do_reset();
    access(SHR_A, 1'b0);
    access(REL_A, 1'b1);
    chk("R4 hold_req dropped", hold_req, 0);
    chk("R4 grant dropped", grant, 0);
    cyc(8);
    chk("R4 ack fell", hold_ack, 0);
    access(SHR_A, 1'b0);
    chk("R4 idle again, new request", hold_req, 1);
  endtask

  task automatic t_outside;
    do_reset();
    access(OUT_A, 1'b0);
    access(OUT_A, 1'b1);
    cyc(4);
    chk("R6 no request outside window", hold_req, 0);
    chk("R6 no error outside window", err_cnt, 0);
  endtask

  task automatic t_errors;
    do_reset();
    access(SHR_A, 1'b1);
    chk("R8 write in idle counted", err_cnt, 1);
    chk("R8 write in idle requests", hold_req, 1);
    do_reset();
    ack_en = 1'b0;
    access(SHR_A, 1'b0);
    access(SHR_A, 1'b0);
    access(SHR_A, 1'b1);
    chk("R8 accesses while pending", err_cnt, 2);
    for (int i = 0; i < 20; i++) access(SHR_A, 1'b0);
    chk("R8 saturation", err_cnt, 15);
  endtask

  task automatic t_mailbox;
    do_reset();
    slv_flag = 4'b0101;
    cyc(4);
    slv_flag = 4'b0000;
    cyc(3);
    chk("R9 slave sets owned bit0", flags, 4'b0001);
    mst_flag = 4'b0101;
    cyc(1);
    mst_flag = 4'b0000;
    cyc(1);
    chk("R9 main clears bit0 sets bit2", flags, 4'b0100);
    slv_flag = 4'b0110;
    cyc(4);
    slv_flag = 4'b0000;
    cyc(3);
    chk("R9 slave sets bit1 clears bit2", flags, 4'b0010);
    chk("R9 flags readable without grant", grant, 0);
  endtask

  task automatic t_timeout;
    do_reset();
    access(SHR_A, 1'b0);
    cyc(40000);
    chk("R5 still granted mid window", grant, 1);
    access(SHR_A + 16'd1, 1'b0);
    cyc(int'(TMO_CYC) - 30);
    chk("R5 access restarted window", grant, 1);
    cyc(60);
    chk("R5 released after idle window", grant, 0);
    chk("R5 hold_req dropped", hold_req, 0);
  endtask

  initial begin
    cyc(2);
    t_reset();
    t_acquire();
    t_sticky();
    t_release();
    t_outside();
    t_errors();
    t_mailbox();
    t_timeout();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule